// File: doc/BRIEF.md
# Reduced Boundary-Scan Test Port

This block gives a memory device a serial boundary-scan test port. A sixteen-state controller steps through its states on the rising edge of the test clock under the mode-select input. A three-bit instruction picks one of three data registers to sit between the serial input and the serial output: a one-bit bypass cell, a 32-bit identification register, or a boundary register whose length is a parameter. The boundary register loads a parallel snapshot of the device pins.

The serial output changes on the falling edge of the test clock. It is driven only while a register is being shifted, and is high impedance at all other times. Two of the instructions raise a flag that the surrounding device uses to put its own outputs into high impedance.

The port is reduced on purpose. Its external-test instruction only isolates the outputs and does not drive scanned values onto pins. There are no update latches on the boundary cells. A synchronous active-high reset stands in for the power-up reset.

Top module: `scan_port_top`

## Requirements
- R1: The mode-select and serial inputs are sampled on the rising edge of `tck`. `tdo` and `tdo_oe` change only after a falling edge and keep their values across the next rising edge.
- R2: Five consecutive rising edges with `tms` high bring the controller to the reset state from any state.
- R3: In reset (after `rst`, or on entering the reset state), the active instruction becomes IDCODE (3'b001), `outs_hiz` is 0, and `tdo` is high impedance.
- R4: On capture of the instruction path, the instruction shift register loads 3'b001. The first three bits shifted out are therefore 1, 0, 0.
- R5: Serial data enters the selected register at its most significant bit and leaves from bit 0. A 32-bit IDCODE scan that is 36 cycles long returns the first four input bits in cycles 33 to 36.
- R6: Under IDCODE, the data capture step loads the 32-bit constant `ID_VALUE`, and it is shifted out starting with bit 0.
- R7: Code 3'b000 (external test) selects the boundary register, which captures `pins` and is read out starting with bit 0, and sets `outs_hiz` to 1.
- R8: Code 3'b111 selects the bypass cell. It captures 0, so the first bit out is 0 and each later bit is the serial input from one cycle earlier. Codes 3'b011, 3'b101 and 3'b110 behave the same way.
- R9: Code 3'b100 (sample) captures `pins` with `outs_hiz` at 0. Code 3'b010 (sample with isolation) captures `pins` with `outs_hiz` at 1.
- R10: `tdo_oe` is 1 exactly while the controller is shifting the instruction or data path. While it is 0, `tdo` is high impedance.
- R11: A newly shifted instruction takes effect only at the falling edge during Update-IR. Until then, `outs_hiz` and the selected path keep their old values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high reset |
| tms | input | 1 | Mode select, sampled on rising edge |
| tdi | input | 1 | Serial data in |
| pins | input | BSR_LEN | Parallel snapshot of device pins |
| tdo | output | 1 | Serial data out, high impedance when not shifting |
| tdo_oe | output | 1 | Output enable of `tdo` |
| outs_hiz | output | 1 | Request to float the device outputs |

## Verification
The scan tests use several patterns. Reading the identity code against a known constant shows the bit order and the capture value. An overlong scan with a marked input pattern shows which end of the register the input enters. A bypass scan with alternating input shows the one-cycle delay apart from a plain wire. Boundary scans of two different pin snapshots under each boundary instruction show capture apart from stale contents, and also show the isolation flag per instruction. The flag is sampled between the shift and update steps of an instruction load, which shows that activation is deferred. A scan cut short by holding mode-select high shows the forced return to reset.

// File: rtl/scan_pkg.sv
package scan_pkg;
  localparam int IR_W = 3;

  typedef enum logic [3:0] {
    S_RESET, S_IDLE,
    S_SEL_DR, S_CAP_DR, S_SH_DR, S_EX1_DR, S_PAU_DR, S_EX2_DR, S_UPD_DR,
    S_SEL_IR, S_CAP_IR, S_SH_IR, S_EX1_IR, S_PAU_IR, S_EX2_IR, S_UPD_IR
  } tap_state_t;

  typedef enum logic [1:0] { PATH_BSR, PATH_ID, PATH_BYP } path_t;

  localparam logic [IR_W-1:0] OP_EXTEST    = 3'b000;
  localparam logic [IR_W-1:0] OP_IDCODE    = 3'b001;
  localparam logic [IR_W-1:0] OP_PROBE_HIZ = 3'b010;
  localparam logic [IR_W-1:0] OP_PROBE     = 3'b100;
  localparam logic [IR_W-1:0] OP_BYPASS    = 3'b111;

  function automatic path_t decode_path(input logic [IR_W-1:0] op);
    case (op)
      OP_EXTEST, OP_PROBE_HIZ, OP_PROBE: decode_path = PATH_BSR;
      OP_IDCODE:                         decode_path = PATH_ID;
      default:                           decode_path = PATH_BYP;
    endcase
  endfunction

  function automatic logic forces_hiz(input logic [IR_W-1:0] op);
    forces_hiz = (op == OP_EXTEST) || (op == OP_PROBE_HIZ);
  endfunction

  function automatic tap_state_t next_state(input tap_state_t s, input logic m);
    case (s)
      S_RESET:  next_state = m ? S_RESET  : S_IDLE;
      S_IDLE:   next_state = m ? S_SEL_DR : S_IDLE;
      S_SEL_DR: next_state = m ? S_SEL_IR : S_CAP_DR;
      S_CAP_DR: next_state = m ? S_EX1_DR : S_SH_DR;
      S_SH_DR:  next_state = m ? S_EX1_DR : S_SH_DR;
      S_EX1_DR: next_state = m ? S_UPD_DR : S_PAU_DR;
      S_PAU_DR: next_state = m ? S_EX2_DR : S_PAU_DR;
      S_EX2_DR: next_state = m ? S_UPD_DR : S_SH_DR;
      S_UPD_DR: next_state = m ? S_SEL_DR : S_IDLE;
      S_SEL_IR: next_state = m ? S_RESET  : S_CAP_IR;
      S_CAP_IR: next_state = m ? S_EX1_IR : S_SH_IR;
      S_SH_IR:  next_state = m ? S_EX1_IR : S_SH_IR;
      S_EX1_IR: next_state = m ? S_UPD_IR : S_PAU_IR;
      S_PAU_IR: next_state = m ? S_EX2_IR : S_PAU_IR;
      S_EX2_IR: next_state = m ? S_UPD_IR : S_SH_IR;
      default:  next_state = m ? S_SEL_DR : S_IDLE;
    endcase
  endfunction
endpackage

// File: rtl/scan_fsm.sv
module scan_fsm
  import scan_pkg::*;
(
  input  logic       tck,
  input  logic       rst,
  input  logic       tms,
  output tap_state_t state
);
  always_ff @(posedge tck) begin
    if (rst) state <= S_RESET;
    else     state <= next_state(state, tms);
  end
endmodule

// File: rtl/scan_ir.sv
module scan_ir
  import scan_pkg::*;
(
  input  logic            tck,
  input  logic            rst,
  input  tap_state_t      state,
  input  logic            tdi,
  output logic            ir_lsb,
  output logic [IR_W-1:0] ir_code,
  output logic            hiz_q
);
  localparam logic [IR_W-1:0] CAPTURE_VAL = {{(IR_W-2){1'b0}}, 2'b01};

  logic [IR_W-1:0] sh_q;

  always_ff @(posedge tck) begin
    if (rst) sh_q <= CAPTURE_VAL;
    else begin
      case (state)
        S_CAP_IR: sh_q <= CAPTURE_VAL;
        S_SH_IR:  sh_q <= {tdi, sh_q[IR_W-1:1]};
        default:  sh_q <= sh_q;
      endcase
    end
  end

  always_ff @(negedge tck) begin
    if (rst || state == S_RESET) begin
      ir_code <= OP_IDCODE;
      hiz_q   <= 1'b0;
    end else if (state == S_UPD_IR) begin
      ir_code <= sh_q;
      hiz_q   <= forces_hiz(sh_q);
    end
  end

  assign ir_lsb = sh_q[0];
endmodule

// File: rtl/scan_dr.sv
module scan_dr
  import scan_pkg::*;
#(
  parameter int          BSR_LEN  = 12,
  parameter int          ID_W     = 32,
  parameter logic [31:0] ID_VALUE = 32'h2B6D_9067
) (
  input  logic               tck,
  input  logic               rst,
  input  tap_state_t         state,
  input  path_t              path,
  input  logic               tdi,
  input  logic [BSR_LEN-1:0] pins,
  output logic               dr_lsb
);
  logic               byp_q;
  logic [ID_W-1:0]    id_q;
  logic [BSR_LEN-1:0] bsr_q;

  always_ff @(posedge tck) begin
    if (rst) begin
      byp_q <= 1'b0;
      id_q  <= '0;
      bsr_q <= '0;
    end else if (state == S_CAP_DR) begin
      case (path)
        PATH_BSR: bsr_q <= pins;
        PATH_ID:  id_q  <= ID_VALUE[ID_W-1:0];
        default:  byp_q <= 1'b0;
      endcase
    end else if (state == S_SH_DR) begin
      case (path)
        PATH_BSR: bsr_q <= {tdi, bsr_q[BSR_LEN-1:1]};
        PATH_ID:  id_q  <= {tdi, id_q[ID_W-1:1]};
        default:  byp_q <= tdi;
      endcase
    end
  end

  always_comb begin
    case (path)
      PATH_BSR: dr_lsb = bsr_q[0];
      PATH_ID:  dr_lsb = id_q[0];
      default:  dr_lsb = byp_q;
    endcase
  end
endmodule

// File: rtl/scan_port_top.sv
module scan_port_top
  import scan_pkg::*;
#(
  parameter int          BSR_LEN  = 12,
  parameter logic [31:0] ID_VALUE = 32'h2B6D_9067
) (
  input  logic               tck,
  input  logic               rst,
  input  logic               tms,
  input  logic               tdi,
  input  logic [BSR_LEN-1:0] pins,
  output logic               tdo,
  output logic               tdo_oe,
  output logic               outs_hiz
);
  tap_state_t      state_w;
  logic [IR_W-1:0] ir_code;
  logic            ir_lsb;
  logic            dr_lsb;
  logic            tdo_q;
  path_t           path;

  scan_fsm u_fsm (.tck(tck), .rst(rst), .tms(tms), .state(state_w));

  scan_ir u_ir (
    .tck(tck), .rst(rst), .state(state_w), .tdi(tdi),
    .ir_lsb(ir_lsb), .ir_code(ir_code), .hiz_q(outs_hiz)
  );

  assign path = decode_path(ir_code);

  scan_dr #(.BSR_LEN(BSR_LEN), .ID_VALUE(ID_VALUE)) u_dr (
    .tck(tck), .rst(rst), .state(state_w), .path(path), .tdi(tdi),
    .pins(pins), .dr_lsb(dr_lsb)
  );

  always_ff @(negedge tck) begin
    if (rst) begin
      tdo_oe <= 1'b0;
      tdo_q  <= 1'b0;
    end else begin
      tdo_oe <= (state_w == S_SH_IR) || (state_w == S_SH_DR);
      tdo_q  <= (state_w == S_SH_IR) ? ir_lsb : dr_lsb;
    end
  end

  assign tdo = tdo_oe ? tdo_q : 1'bz;
endmodule

// File: rtl/scan_port_chk.sv
module scan_port_chk
  import scan_pkg::*;
(
  input logic            tck,
  input logic            rst,
  input logic            tms,
  input tap_state_t      state_w,
  input logic [IR_W-1:0] ir_code,
  input logic            tdo_oe,
  input logic            outs_hiz
);
  logic [2:0] ones_cnt;

  always_ff @(posedge tck) begin
    if (rst)      ones_cnt <= '0;
    else if (!tms) ones_cnt <= '0;
    else if (ones_cnt != 3'd7) ones_cnt <= ones_cnt + 3'd1;
  end

  // R2
  five_ones_reset_chk: assert property (@(posedge tck) disable iff (rst)
    (ones_cnt >= 3'd5) |-> (state_w == S_RESET));

  // R3
  reset_state_chk: assert property (@(posedge tck) disable iff (rst)
    (state_w == S_RESET) |-> (ir_code == OP_IDCODE && !tdo_oe && !outs_hiz));

  // R10
  oe_in_shift_chk: assert property (@(posedge tck) disable iff (rst)
    tdo_oe |-> (state_w == S_SH_DR || state_w == S_SH_IR));

  // R10
  shift_has_oe_chk: assert property (@(posedge tck) disable iff (rst)
    (state_w == S_SH_DR || state_w == S_SH_IR) |-> tdo_oe);

  // R11
  instr_hold_chk: assert property (@(negedge tck) disable iff (rst)
    (state_w != S_UPD_IR && state_w != S_RESET) |=> ($stable(ir_code) && $stable(outs_hiz)));
endmodule

bind scan_port_top scan_port_chk u_chk (
  .tck(tck), .rst(rst), .tms(tms), .state_w(state_w),
  .ir_code(ir_code), .tdo_oe(tdo_oe), .outs_hiz(outs_hiz)
);

// File: tb/scan_port_top_test.sv
module scan_port_top_test;
  localparam int          BSR_LEN = 12;
  localparam logic [31:0] ID_VAL  = 32'h2B6D_9067;

  logic tck = 1'b0;
  logic rst = 1'b1;
  logic tms = 1'b1;
  logic tdi = 1'b0;
  logic [BSR_LEN-1:0] pins = '0;
  wire  tdo;
  logic tdo_oe, outs_hiz;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic  exp_q[$];
  logic  act_q[$];
  string tag_q[$];

  scan_port_top #(.BSR_LEN(BSR_LEN), .ID_VALUE(ID_VAL)) uut (
    .tck(tck), .rst(rst), .tms(tms), .tdi(tdi), .pins(pins),
    .tdo(tdo), .tdo_oe(tdo_oe), .outs_hiz(outs_hiz)
  );

  always #10 tck = ~tck;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(posedge tck) begin
    while (act_q.size() > 0 && exp_q.size() > 0) begin
      logic a, e;
      string t;
      a = act_q.pop_front();
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(a === e, t, {31'b0, a}, {31'b0, e});
    end
  end

  // one TCK cycle: returns TDO for the current state, then applies tms/tdi
  task automatic cyc(input logic m, input logic d, output logic o);
    logic oe;
    @(negedge tck);
    #5;
    o  = tdo;
    oe = tdo_oe;
    tms = m;
    tdi = d;
    @(posedge tck);
    #1;
    if (oe) chk(tdo === o, "R1 tdo stable over rising edge", {31'b0, tdo}, {31'b0, o});
  endtask

  task automatic go_reset();
    logic o;
    for (int i = 0; i < 5; i++) cyc(1'b1, 1'b0, o);
    cyc(1'b0, 1'b0, o);
  endtask

  task automatic load_ir(input logic [2:0] code, input bit chk_cap);
    logic o;
    cyc(1'b1, 1'b0, o);
    cyc(1'b1, 1'b0, o);
    cyc(1'b0, 1'b0, o);
    cyc(1'b0, 1'b0, o);
    for (int i = 0; i < 3; i++) begin
      cyc(i == 2, code[i], o);
      if (chk_cap) begin
        exp_q.push_back(i == 0);
        act_q.push_back(o);
        tag_q.push_back("R4 captured instruction bit");
      end
    end
  endtask

  task automatic finish_ir();
    logic o;
    cyc(1'b1, 1'b0, o);
    cyc(1'b0, 1'b0, o);
  endtask

  // expected bits given in exp_bits[i] for cycle i
  task automatic scan_dr(input int n, input logic [63:0] din, input logic [63:0] exp_bits, input string tag);
    logic o;
    cyc(1'b1, 1'b0, o);
    cyc(1'b0, 1'b0, o);
    cyc(1'b0, 1'b0, o);
    for (int i = 0; i < n; i++) begin
      cyc(i == n - 1, din[i], o);
      exp_q.push_back(exp_bits[i]);
      act_q.push_back(o);
      tag_q.push_back(tag);
    end
    cyc(1'b1, 1'b0, o);
    cyc(1'b0, 1'b0, o);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic o;
    logic [63:0] e;
    logic [63:0] d;
    repeat (3) @(negedge tck);
    #5 rst = 1'b0;
    #2;
    chk(tdo === 1'bz && tdo_oe === 1'b0, "R3 tdo floating after reset", {31'b0, tdo_oe}, 32'h0);
    chk(outs_hiz === 1'b0, "R3 outs_hiz low after reset", {31'b0, outs_hiz}, 32'h0);
    cyc(1'b0, 1'b0, o);

    // R6: IDCODE active by default
    scan_dr(32, 64'h0, {32'h0, ID_VAL}, "R6 identity code bit");
    chk(tdo === 1'bz, "R10 tdo floating in idle", {31'b0, tdo}, 32'h0);

    // R5: overlong scan
    d = 64'h0000_000B_0000_0000 | 64'h5;
    e = {28'h0, d[3:0], ID_VAL};
    scan_dr(36, d, e, "R5 msb entry lsb exit");

    // R4 and R8: bypass
    load_ir(3'b111, 1'b1);
    finish_ir();
    d = 64'hA6;
    e = {d[62:0], 1'b0};
    scan_dr(8, d, e, "R8 bypass delay");

    // R8: unassigned codes behave as bypass
    for (int k = 0; k < 3; k++) begin
      logic [2:0] c;
      c = (k == 0) ? 3'b011 : (k == 1) ? 3'b101 : 3'b110;
      load_ir(c, 1'b0);
      finish_ir();
      d = 64'h3C;
      e = {d[62:0], 1'b0};
      scan_dr(6, d, e, "R8 unassigned code as bypass");
    end

    // R9: sample
    load_ir(3'b100, 1'b0);
    finish_ir();
    chk(outs_hiz === 1'b0, "R9 sample keeps outputs", {31'b0, outs_hiz}, 32'h0);
    pins = 12'hA5C;
    scan_dr(BSR_LEN, 64'h0, {52'h0, 12'hA5C}, "R9 sample capture");

    // R11: load EXTEST, flag unchanged until update
    load_ir(3'b000, 1'b0);
    cyc(1'b1, 1'b0, o); // now in Update-IR, before its falling edge
    chk(outs_hiz === 1'b0, "R11 flag held before update", {31'b0, outs_hiz}, 32'h0);
    cyc(1'b0, 1'b0, o);
    chk(outs_hiz === 1'b1, "R7 extest raises flag", {31'b0, outs_hiz}, 32'h1);
    pins = 12'h3B1;
    scan_dr(BSR_LEN, 64'h0, {52'h0, 12'h3B1}, "R7 extest capture");

    // R9: sample with isolation
    load_ir(3'b010, 1'b0);
    finish_ir();
    chk(outs_hiz === 1'b1, "R9 isolating sample flag", {31'b0, outs_hiz}, 32'h1);
    pins = 12'h6E2;
    scan_dr(BSR_LEN, 64'h0, {52'h0, 12'h6E2}, "R9 isolating sample capture");

    // R2/R3: abort from Shift-DR with five ones
    cyc(1'b1, 1'b0, o);
    cyc(1'b0, 1'b0, o);
    cyc(1'b0, 1'b0, o);
    cyc(1'b0, 1'b0, o);
    chk(tdo_oe === 1'b1, "R10 enable in shift", {31'b0, tdo_oe}, 32'h1);
    for (int i = 0; i < 5; i++) cyc(1'b1, 1'b0, o);
    @(negedge tck);
    #5;
    chk(outs_hiz === 1'b0, "R2 five ones reach reset", {31'b0, outs_hiz}, 32'h0);
    chk(tdo === 1'bz, "R3 tdo floating in reset", {31'b0, tdo}, 32'h0);
    cyc(1'b0, 1'b0, o);
    scan_dr(32, 64'h0, {32'h0, ID_VAL}, "R3 identity code after reset");

    go_reset();
    repeat (3) @(posedge tck);
    #1;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule